// File: doc/BRIEF.md
# Mode-Configurable Lookup-Table RAM Cell

This block is a tiny RAM made from two 16-entry, 1-bit lookup-table storage halves, called F and G. A static mode input chooses how they are organised. In the two-column mode the halves are two independent 16x1 columns, each with its own address and data bit. In the one-column mode they form a single 32x1 RAM: the second data pin becomes the top address bit and chooses which half is written and read.

Writes are synchronous. A parameter picks the active edge of the write clock, and the same edge applies to both halves. Reads are combinational from the current address. An output flip-flop captures the read data. A static input decides whether that flip-flop is clocked on the write edge or on the opposite edge of the same clock. The block is meant to sit beside other cell logic as a small scratch store or a shift-free delay element.

Top module: `lutram_cell`

## Requirements
- R1: In two-column mode (`cfg_mode`=0), a write stores `din0` at `addr_f` in half F and `din1` at `addr_g` in half G, independently.
- R2: In two-column mode, `rd_comb[0]` is F[`addr_f`] and `rd_comb[1]` is G[`addr_g`], combinationally.
- R3: In one-column mode (`cfg_mode`=1), `din1` acts as address bit 4. `din0` is written to F[`addr_f`] when `din1`=0 and to G[`addr_f`] when `din1`=1. The other half and `addr_g` are left alone.
- R4: In one-column mode, `rd_comb[0]` is G[`addr_f`] when `din1`=1 and F[`addr_f`] otherwise, and `rd_comb[1]` is 0.
- R5: With `wr_en` low at the active edge, no location changes.
- R6: Writes happen only on the active write edge: the rising edge when `WCLK_FALLING`=0, the falling edge when it is 1. The other edge never writes.
- R7: Right after a write edge, `rd_comb` at the written address shows the new value.
- R8: With `cfg_reg_late`=0, `rd_reg` captures `rd_comb` on the write edge. During a write it therefore holds the value read before the write.
- R9: With `cfg_reg_late`=1, `rd_reg` captures `rd_comb` on the edge opposite the write edge.
- R10: A synchronous active-high `rst` clears `rd_reg` to 0. RAM contents are not reset, and writes made while `rst` is high still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; also clocks the output flip-flop |
| rst | input | 1 | Synchronous active-high reset of the output flip-flop |
| cfg_mode | input | 1 | 0 = two 16x1 columns, 1 = one 32x1 column (static) |
| cfg_reg_late | input | 1 | 0 = output flop on write edge, 1 = on opposite edge (static) |
| addr_f | input | AW | Address of half F (both halves in one-column mode) |
| addr_g | input | AW | Address of half G in two-column mode |
| din0 | input | 1 | Data bit for F, or the only data bit in one-column mode |
| din1 | input | 1 | Data bit for G, or address bit 4 in one-column mode |
| wr_en | input | 1 | Active-high write enable, sampled on the write edge |
| rd_comb | output | 2 | Combinational read data |
| rd_reg | output | 2 | Registered read data |

## Verification
The assertions assume that `cfg_mode` and `cfg_reg_late` change only while `rst` is high. They also assume that every location has been written before reset is released. Until then the read data is unknown, and the hold and capture properties cannot compare it. The stimulus follows both assumptions. It fills all 32 locations while reset is asserted. It changes configuration only inside a reset window that is held for two further clock cycles. Every input change happens a quarter period after the rising edge, so neither a rising-edge writer nor a falling-edge writer sees an input move at its active edge.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

    localparam int HALF_AW = 4;

    typedef enum logic {
        MODE_TWO_COL = 1'b0,
        MODE_ONE_COL = 1'b1
    } ram_mode_e;

    typedef struct packed {
        logic we;
        logic data;
    } half_wr_t;

    // Combine the two half read bits into the cell's output pair
    function automatic logic [1:0] merge_read(input logic one_col, input logic hi_sel,
                                              input logic f_bit, input logic g_bit);
        logic [1:0] r;
        if (one_col) r = {1'b0, (hi_sel ? g_bit : f_bit)};
        else         r = {g_bit, f_bit};
        return r;
    endfunction

endpackage

// File: rtl/lut16_ram.sv
module lut16_ram
    import lutram_pkg::*;
#(
    parameter int AW           = HALF_AW,
    parameter bit WCLK_FALLING = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  half_wr_t      wr,
    input  logic [AW-1:0] addr,
    output logic          rdata
);
    localparam int DEPTH = 1 << AW;

    logic mem [DEPTH];

    generate
        if (WCLK_FALLING) begin : g_fall
            always_ff @(negedge clk) begin
                if (wr.we) mem[addr] <= wr.data;
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                if (wr.we) mem[addr] <= wr.data;
            end
        end
    endgenerate

    assign rdata = mem[addr];

    // Active write edge as a rising edge, used by the checks below
    logic wclk;
    assign wclk = clk ^ WCLK_FALLING;

    // R5: an idle write edge leaves the addressed word unchanged
    a_r5_idle_keeps: assert property (@(posedge wclk) disable iff (rst)
        !wr.we |=> (addr != $past(addr)) || $stable(rdata));

    // R7: after a write edge the same address reads the new bit
    a_r7_write_lands: assert property (@(posedge wclk) disable iff (rst)
        wr.we |=> (addr != $past(addr)) || (rdata == $past(wr.data)));

endmodule

// File: rtl/lutram_route.sv
module lutram_route
    import lutram_pkg::*;
#(
    parameter int AW = HALF_AW
) (
    input  logic          mode,
    input  logic [AW-1:0] addr_f,
    input  logic [AW-1:0] addr_g,
    input  logic          din0,
    input  logic          din1,
    input  logic          wr_en,
    input  logic          rd_f,
    input  logic          rd_g,
    output half_wr_t      wr_f,
    output half_wr_t      wr_g,
    output logic [AW-1:0] a_f,
    output logic [AW-1:0] a_g,
    output logic [1:0]    rd_comb
);
    logic one_col;
    assign one_col = (ram_mode_e'(mode) == MODE_ONE_COL);

    // In one-column mode both halves share the low address; din1 picks the half
    assign a_f = addr_f;
    assign a_g = one_col ? addr_f : addr_g;

    assign wr_f.we   = wr_en & ~(one_col & din1);
    assign wr_f.data = din0;
    assign wr_g.we   = wr_en & (~one_col | din1);
    assign wr_g.data = one_col ? din0 : din1;

    assign rd_comb = merge_read(one_col, din1, rd_f, rd_g);

endmodule

// File: rtl/lutram_oreg.sv
module lutram_oreg #(
    parameter int W            = 2,
    parameter bit WCLK_FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         late,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_wedge;
    logic [W-1:0] q_oedge;

    generate
        if (WCLK_FALLING) begin : g_fall
            always_ff @(negedge clk) q_wedge <= rst ? '0 : d;
            always_ff @(posedge clk) q_oedge <= rst ? '0 : d;
        end else begin : g_rise
            always_ff @(posedge clk) q_wedge <= rst ? '0 : d;
            always_ff @(negedge clk) q_oedge <= rst ? '0 : d;
        end
    endgenerate

    assign q = late ? q_oedge : q_wedge;

    logic wclk;
    assign wclk = clk ^ WCLK_FALLING;

    // R8: on the write edge the output takes the pre-edge read value
    a_r8_same_edge: assert property (@(posedge wclk) disable iff (rst)
        !late |=> q == $past(d));

    // R9: on the opposite edge the output takes the read value of that edge
    a_r9_opposite_edge: assert property (@(negedge wclk) disable iff (rst)
        late |=> q == $past(d));

endmodule

// File: rtl/lutram_cell.sv
module lutram_cell
    import lutram_pkg::*;
#(
    parameter int AW           = HALF_AW,
    parameter bit WCLK_FALLING = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_mode,
    input  logic          cfg_reg_late,
    input  logic [AW-1:0] addr_f,
    input  logic [AW-1:0] addr_g,
    input  logic          din0,
    input  logic          din1,
    input  logic          wr_en,
    output logic [1:0]    rd_comb,
    output logic [1:0]    rd_reg
);
    localparam int OUT_W = 2;

    half_wr_t      wr_f, wr_g;
    logic [AW-1:0] a_f, a_g;
    logic          rd_f, rd_g;

    lutram_route #(.AW(AW)) u_route (
        .mode    (cfg_mode),
        .addr_f  (addr_f),
        .addr_g  (addr_g),
        .din0    (din0),
        .din1    (din1),
        .wr_en   (wr_en),
        .rd_f    (rd_f),
        .rd_g    (rd_g),
        .wr_f    (wr_f),
        .wr_g    (wr_g),
        .a_f     (a_f),
        .a_g     (a_g),
        .rd_comb (rd_comb)
    );

    lut16_ram #(.AW(AW), .WCLK_FALLING(WCLK_FALLING)) u_half_f (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_f),
        .addr  (a_f),
        .rdata (rd_f)
    );

    lut16_ram #(.AW(AW), .WCLK_FALLING(WCLK_FALLING)) u_half_g (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_g),
        .addr  (a_g),
        .rdata (rd_g)
    );

    lutram_oreg #(.W(OUT_W), .WCLK_FALLING(WCLK_FALLING)) u_oreg (
        .clk  (clk),
        .rst  (rst),
        .late (cfg_reg_late),
        .d    (rd_comb),
        .q    (rd_reg)
    );

    // Configuration is static outside reset (assumed by R3/R4/R8/R9)
    a_r4_cfg_static: assert property (@(posedge clk) disable iff (rst)
        $stable(cfg_mode) && $stable(cfg_reg_late));

    // R4: one-column mode never drives the upper output bit
    a_r4_upper_idle: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |-> rd_comb[1] == 1'b0);

endmodule

// File: tb/tb_lutram_cell.sv
module tb_lutram_cell;

    localparam int CLK_NS = 4;
    localparam int AW     = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_mode, cfg_reg_late;
    logic [AW-1:0] addr_f, addr_g;
    logic          din0, din1, wr_en;
    logic [1:0]    comb_r, reg_r, comb_f, reg_f;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Behavioural contents: index a is half F, 16+a is half G
    logic [31:0] mem_r, mem_f;

    always #(CLK_NS/2) clk = ~clk;

    lutram_cell #(.AW(AW), .WCLK_FALLING(1'b0)) dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_reg_late(cfg_reg_late),
        .addr_f(addr_f), .addr_g(addr_g), .din0(din0), .din1(din1), .wr_en(wr_en),
        .rd_comb(comb_r), .rd_reg(reg_r));

    lutram_cell #(.AW(AW), .WCLK_FALLING(1'b1)) dut_fall (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_reg_late(cfg_reg_late),
        .addr_f(addr_f), .addr_g(addr_g), .din0(din0), .din1(din1), .wr_en(wr_en),
        .rd_comb(comb_f), .rd_reg(reg_f));

    function automatic logic [1:0] ref_read(input logic [31:0] m, input logic one_col,
                                            input logic [3:0] af, input logic [3:0] ag,
                                            input logic hi);
        if (one_col) return {1'b0, m[hi ? 16 + af : af]};
        return {m[16 + ag], m[af]};
    endfunction

    function automatic logic [31:0] ref_write(input logic [31:0] m, input logic one_col,
                                              input logic [3:0] af, input logic [3:0] ag,
                                              input logic d0, input logic d1, input logic we);
        logic [31:0] n = m;
        if (we) begin
            if (one_col) n[d1 ? 16 + af : af] = d0;
            else begin
                n[af]      = d0;
                n[16 + ag] = d1;
            end
        end
        return n;
    endfunction

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Called a quarter period after a rising edge with new inputs already driven
    task automatic one_cycle(input logic one_col, input logic late);
        logic [1:0] old_r, old_f, new_r, new_f;
        old_r = ref_read(mem_r, one_col, addr_f, addr_g, din1);
        old_f = ref_read(mem_f, one_col, addr_f, addr_g, din1);
        #2;  // just after the falling edge
        mem_f = ref_write(mem_f, one_col, addr_f, addr_g, din0, din1, wr_en);
        new_f = ref_read(mem_f, one_col, addr_f, addr_g, din1);
        chk(wr_en ? (one_col ? "R3 falling-edge write" : "R1 falling-edge write")
                  : "R5 idle edge", comb_f, new_f);
        chk("R6 rising writer untouched by falling edge", comb_r, old_r);
        if (late) chk("R9 rising part reg on opposite edge", reg_r, old_r);
        else      chk("R8 falling part reg on write edge", reg_f, old_f);
        @(posedge clk); #1;
        mem_r = ref_write(mem_r, one_col, addr_f, addr_g, din0, din1, wr_en);
        new_r = ref_read(mem_r, one_col, addr_f, addr_g, din1);
        chk(wr_en ? "R7 read after write" : (one_col ? "R4 one-column read" : "R2 two-column read"),
            comb_r, new_r);
        chk("R6 falling writer untouched by rising edge", comb_f, new_f);
        chk(late ? "R9 rising part reg" : "R8 rising part reg", reg_r, old_r);
        chk(late ? "R9 falling part reg opposite edge" : "R8 falling part reg",
            reg_f, late ? new_f : old_f);
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_mode = 1'b0; cfg_reg_late = 1'b0;
        addr_f = '0; addr_g = '0; din0 = 1'b0; din1 = 1'b0; wr_en = 1'b0;
        mem_r = '0; mem_f = '0;
        @(posedge clk); #1;
        // R10: fill every location while reset is held
        for (int a = 0; a < 16; a++) begin
            addr_f = 4'(a); addr_g = 4'(15 - a);
            din0 = 1'($urandom); din1 = 1'($urandom); wr_en = 1'b1;
            mem_r = ref_write(mem_r, 1'b0, addr_f, addr_g, din0, din1, 1'b1);
            mem_f = mem_r;
            @(posedge clk); #1;
        end
        wr_en = 1'b0;
        chk("R10 reg cleared in reset (rising part)", reg_r, 2'b00);
        chk("R10 reg cleared in reset (falling part)", reg_f, 2'b00);
        chk("R10 contents written under reset", comb_r,
            ref_read(mem_r, 1'b0, addr_f, addr_g, din1));

        for (int ph = 0; ph < 4; ph++) begin
            logic one_col, late;
            one_col = ph[1];
            late    = ph[0];
            rst = 1'b1; wr_en = 1'b0;
            cfg_mode = one_col; cfg_reg_late = late;
            @(posedge clk); #1;
            @(posedge clk); #1;
            chk("R10 reg cleared after reset", reg_r, 2'b00);
            chk("R10 reg cleared after reset", reg_f, 2'b00);
            rst = 1'b0;
            for (int k = 0; k < 200; k++) begin
                if (k % 4 != 1) begin
                    addr_f = (k < 32) ? 4'(k) : 4'($urandom);
                    addr_g = 4'($urandom);
                end
                din0  = 1'($urandom);
                din1  = (k < 32) ? 1'(k >> 4) : 1'($urandom);
                wr_en = (k % 5 != 3);
                one_cycle(one_col, late);
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule